// File: doc/BRIEF.md
# SIMD Complex Multiply-Accumulate Unit

This block is a fixed-point vector multiply-accumulate datapath. Each accepted beat carries one 32-bit operand pair. The pair is split into one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Every lane multiplies its two operands and adds the product into a private accumulator field. In complex mode, each pair of neighbouring lanes holds one complex number: the lower lane is the real part and the upper lane is the imaginary part. The two accumulator fields of that pair then collect the real and imaginary parts of the complex product. All widths share one array of sixteen byte-by-byte multipliers. The array is regrouped according to the lane width, and complex mode crosses lanes by choosing which byte products feed each field.

The input and output are valid/ready streams. A beat transfers on any rising edge where `in_valid` and `in_ready` are both high. The width, complex, signed and clear controls are sampled with that beat and travel with it through the three pipeline registers. `out_valid` marks the beat in which `out_acc` shows the accumulator state after one transfer. The downstream consumer takes that beat on an edge where `out_ready` is high. While the consumer holds `out_ready` low with a result pending, the whole pipeline freezes, and `in_ready` stays low until the result is taken.

Top module: `simd_cmac`

## Requirements
- R1: After reset, `out_valid` is 0, `out_acc` is all zeros and `in_ready` is 1.
- R2: Width code `in_width` selects the lane width LW: 2'b00 gives four 8-bit lanes, 2'b01 gives two 16-bit lanes, and 2'b10 or 2'b11 gives one 32-bit lane. Lane k takes operand bits [k*LW +: LW]. In real mode, lane k adds a_k*b_k into field k of `out_acc`, which is bits [k*3*LW +: 3*LW].
- R3: With `in_signed`=1, lane operands are two's complement. With `in_signed`=0, they are unsigned.
- R4: With `in_cplx`=1, lane 2k is the real part and lane 2k+1 is the imaginary part. Field 2k receives ar*br - ai*bi and field 2k+1 receives ar*bi + ai*br.
- R5: Complex mode with a 32-bit width code uses the two 16-bit halves as the real part (bits 15:0) and the imaginary part (bits 31:16). Its results go into two 48-bit fields, exactly as in 16-bit complex mode.
- R6: A beat with `in_clear`=1 loads each field with its new term instead of adding the term to the old value.
- R7: A beat that transfers before rising edge t shows its result on `out_acc` with `out_valid`=1 after edge t+2, which is three cycles after the beat was presented. One beat can transfer on every edge.
- R8: The controls of each beat stay with that beat, so back-to-back beats in different modes each produce their own correct result.
- R9: Each field wraps modulo 2^(3*LW). No carry crosses into a neighbouring field.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. During that time `out_acc` and `out_valid` hold, and an offered input beat is not taken.
- R11: Cycles without a transfer leave the accumulators unchanged and produce no output beat, whatever values are on the data and control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The pipeline can take a beat |
| in_a | input | 32 | First operand vector |
| in_b | input | 32 | Second operand vector |
| in_width | input | 2 | Lane width code |
| in_cplx | input | 1 | Complex mode for this beat |
| in_signed | input | 1 | Two's complement operands for this beat |
| in_clear | input | 1 | Load instead of accumulate |
| out_valid | output | 1 | A result beat is shown |
| out_ready | input | 1 | The consumer takes the result beat |
| out_acc | output | 96 | Accumulator fields, laid out by lane width |

## Verification
Some properties are checked on every cycle. Unsigned byte products never come out negative. A valid bit only rises when the stage before it held a beat. The accumulators never move on a cycle without a transfer. The shown result and its valid flag hold while the consumer stalls. Only the bench scenarios can show the arithmetic itself. These scenarios cover the cross-lane real and imaginary sums, signed against unsigned reading of the same bits, the field wrap with no carry into a neighbour, the exact three-cycle result timing, and correct results when the mode changes on every beat of a burst.

// File: rtl/simd_cmac_pkg.sv
package simd_cmac_pkg;
  localparam int PPW = 18;          // signed 9x9 byte product
  localparam int GUARD_MUL = 3;     // field width = GUARD_MUL * lane width

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_32B = 2'b11
  } width_e;

  // element width in bytes; complex at 32 bits works on 16-bit halves
  function automatic logic [2:0] elem_bytes(input logic [1:0] w, input logic cplx);
    if (w == WID_8) return 3'd1;
    if (w == WID_16) return 3'd2;
    return cplx ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/cmac_pp_stage.sv
module cmac_pp_stage
  import simd_cmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic                         in_valid,
  input  logic [DW-1:0]                a,
  input  logic [DW-1:0]                b,
  input  logic                         sgn,
  input  logic                         cplx,
  input  logic                         clr,
  input  logic [2:0]                   eb,
  output logic                         v1,
  output logic                         sgn_q,
  output logic                         cplx_q,
  output logic                         clr_q,
  output logic [2:0]                   eb_q,
  output logic [NB*NB-1:0][PPW-1:0]    pp_q
);
  localparam int NB = DW / 8;

  logic [NB*NB-1:0][PPW-1:0] pp_d;
  logic [NB*NB-1:0]          pp_msb;

  always_comb begin
    logic [8:0] da;
    logic [8:0] db;
    int ebi;
    ebi = int'(eb);
    da = '0;
    db = '0;
    for (int i = 0; i < NB; i++) begin
      for (int j = 0; j < NB; j++) begin
        da = {sgn && ((i % ebi) == ebi - 1) && a[8*i+7], a[8*i +: 8]};
        db = {sgn && ((j % ebi) == ebi - 1) && b[8*j+7], b[8*j +: 8]};
        pp_d[i*NB+j] = $signed(da) * $signed(db);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      sgn_q  <= 1'b0;
      cplx_q <= 1'b0;
      clr_q  <= 1'b0;
      eb_q   <= 3'd1;
      pp_q   <= '0;
    end else if (adv) begin
      v1     <= in_valid;
      sgn_q  <= sgn;
      cplx_q <= cplx;
      clr_q  <= clr;
      eb_q   <= eb;
      pp_q   <= pp_d;
    end
  end

  always_comb begin
    for (int k = 0; k < NB*NB; k++) pp_msb[k] = pp_q[k][PPW-1];
  end

  // unsigned operands can never yield a negative byte product
  assert_unsigned_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !sgn_q) |-> (pp_msb == '0));
endmodule

// File: rtl/cmac_reduce_stage.sv
module cmac_reduce_stage
  import simd_cmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic                         v1,
  input  logic                         cplx1,
  input  logic                         clr1,
  input  logic [2:0]                   eb1,
  input  logic [NB*NB-1:0][PPW-1:0]    pp,
  output logic                         v2,
  output logic                         clr2,
  output logic [2:0]                   eb2,
  output logic [ACCW-1:0]              p1_q,
  output logic [ACCW-1:0]              p2_q,
  output logic [NB-1:0]                cin_q
);
  localparam int NB   = DW / 8;
  localparam int ACCW = GUARD_MUL * DW;
  localparam int SEGB = GUARD_MUL * 8;

  logic [ACCW-1:0] p1_d, p2_d;
  logic [NB-1:0]   cin_d;

  // product of element e of a with element f of b, from byte products
  function automatic logic [ACCW-1:0] elem(input logic [NB*NB-1:0][PPW-1:0] pv,
                                           input int e, input int f, input int ebi);
    logic [ACCW-1:0] sum;
    logic [PPW-1:0]  t;
    sum = '0;
    for (int i = 0; i < NB; i++) begin
      for (int j = 0; j < NB; j++) begin
        if (i < ebi && j < ebi) begin
          t = pv[(e*ebi+i)*NB + (f*ebi+j)];
          sum = sum + ({{(ACCW-PPW){t[PPW-1]}}, t} << (8*(i+j)));
        end
      end
    end
    return sum;
  endfunction

  always_comb begin
    int ebi;
    int sb;
    int k;
    logic [ACCW-1:0] mask;
    logic [ACCW-1:0] e1;
    logic [ACCW-1:0] e2;
    p1_d  = '0;
    p2_d  = '0;
    cin_d = '0;
    ebi   = int'(eb1);
    sb    = 0;
    k     = 0;
    mask  = '0;
    e1    = '0;
    e2    = '0;
    for (int s = 0; s < NB; s++) begin
      if (s * ebi < NB) begin
        sb   = SEGB * ebi;
        mask = (ACCW'(1) << sb) - ACCW'(1);
        k    = s - (s % 2);
        if (!cplx1) begin
          e1 = elem(pp, s, s, ebi);
          e2 = '0;
        end else if ((s % 2) == 0) begin
          e1 = elem(pp, k, k, ebi);
          e2 = ~elem(pp, k + 1, k + 1, ebi);
          cin_d[s] = 1'b1;
        end else begin
          e1 = elem(pp, k, k + 1, ebi);
          e2 = elem(pp, k + 1, k, ebi);
        end
        p1_d = p1_d | ((e1 & mask) << (s * sb));
        p2_d = p2_d | ((e2 & mask) << (s * sb));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2    <= 1'b0;
      clr2  <= 1'b0;
      eb2   <= 3'd1;
      p1_q  <= '0;
      p2_q  <= '0;
      cin_q <= '0;
    end else if (adv) begin
      v2    <= v1;
      clr2  <= clr1;
      eb2   <= eb1;
      p1_q  <= p1_d;
      p2_q  <= p2_d;
      cin_q <= cin_d;
    end
  end

  assert_mid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v2) |-> $past(v1));
endmodule

// File: rtl/cmac_acc_stage.sv
module cmac_acc_stage
  import simd_cmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            v2,
  input  logic            clr2,
  input  logic [2:0]      eb2,
  input  logic [ACCW-1:0] p1,
  input  logic [ACCW-1:0] p2,
  input  logic [NB-1:0]   cin,
  output logic            v3,
  output logic [ACCW-1:0] acc_q
);
  localparam int NB   = DW / 8;
  localparam int ACCW = GUARD_MUL * DW;
  localparam int SEGB = GUARD_MUL * 8;

  logic [ACCW-1:0] acc_d;

  // per field: carry-save row over (old, term1, term2), then one carry-propagate add
  always_comb begin
    int ebi;
    int sb;
    logic [ACCW-1:0] mask, base, x, y, sv, cv, nv;
    acc_d = '0;
    ebi   = int'(eb2);
    sb    = 0;
    mask  = '0;
    base  = '0;
    x     = '0;
    y     = '0;
    sv    = '0;
    cv    = '0;
    nv    = '0;
    for (int s = 0; s < NB; s++) begin
      if (s * ebi < NB) begin
        sb   = SEGB * ebi;
        mask = (ACCW'(1) << sb) - ACCW'(1);
        base = clr2 ? '0 : ((acc_q >> (s * sb)) & mask);
        x    = (p1 >> (s * sb)) & mask;
        y    = (p2 >> (s * sb)) & mask;
        sv   = base ^ x ^ y;
        cv   = ((base & x) | (base & y) | (x & y)) << 1;
        nv   = (sv + cv + ACCW'(cin[s])) & mask;
        acc_d = acc_d | (nv << (s * sb));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3    <= 1'b0;
      acc_q <= '0;
    end else if (adv) begin
      v3 <= v2;
      if (v2) acc_q <= acc_d;
    end
  end

  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && v2) |=> $stable(acc_q));

  assert_out_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v3) |-> $past(v2));
endmodule

// File: rtl/simd_cmac.sv
module simd_cmac
  import simd_cmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_a,
  input  logic [DW-1:0]              in_b,
  input  logic [1:0]                 in_width,
  input  logic                       in_cplx,
  input  logic                       in_signed,
  input  logic                       in_clear,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [GUARD_MUL*DW-1:0]    out_acc
);
  localparam int NB   = DW / 8;
  localparam int ACCW = GUARD_MUL * DW;

  logic                      adv;
  logic                      v1, v2;
  logic                      sgn1, cplx1, clr1, clr2;
  logic [2:0]                eb1, eb2;
  logic [NB*NB-1:0][PPW-1:0] pp;
  logic [ACCW-1:0]           p1, p2;
  logic [NB-1:0]             cin;

  // whole pipeline moves unless a shown result is being refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  cmac_pp_stage #(.DW(DW)) u_pp (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .a(in_a), .b(in_b), .sgn(in_signed), .cplx(in_cplx), .clr(in_clear),
    .eb(elem_bytes(in_width, in_cplx)),
    .v1(v1), .sgn_q(sgn1), .cplx_q(cplx1), .clr_q(clr1), .eb_q(eb1), .pp_q(pp)
  );

  cmac_reduce_stage #(.DW(DW)) u_red (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v1(v1), .cplx1(cplx1), .clr1(clr1),
    .eb1(eb1), .pp(pp), .v2(v2), .clr2(clr2), .eb2(eb2),
    .p1_q(p1), .p2_q(p2), .cin_q(cin)
  );

  cmac_acc_stage #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v2(v2), .clr2(clr2), .eb2(eb2),
    .p1(p1), .p2(p2), .cin(cin), .v3(out_valid), .acc_q(out_acc)
  );

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc)));

  // sgn1 is used only by the byte-product stage checks
  assert_sign_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> !$isunknown(sgn1));
endmodule

// File: tb/test_simd_cmac.sv
`timescale 1ns/100ps
module test_simd_cmac;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_cplx = 1'b0, in_signed = 1'b0, in_clear = 1'b0;
  logic out_ready = 1'b1;
  logic [1:0] in_width = 2'b00;
  logic [31:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [95:0] out_acc;

  always #2.5 clk = ~clk;

  simd_cmac i_simd_cmac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_width(in_width), .in_cplx(in_cplx),
    .in_signed(in_signed), .in_clear(in_clear), .out_valid(out_valid),
    .out_ready(out_ready), .out_acc(out_acc)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit lat_on = 1'b1;
  logic [95:0] model_acc = '0;
  logic [95:0] qexp[$];
  int          qcyc[$];
  string       qtag[$];

  // stimulus table: {width, cplx, signed, clear, a, b}
  localparam logic [68:0] VEC [12] = '{
    {2'b00, 1'b0, 1'b1, 1'b1, 32'h7F80_FF01, 32'h0203_FF80},
    {2'b00, 1'b0, 1'b1, 1'b0, 32'h1122_3344, 32'hF0E0_D0C0},
    {2'b00, 1'b1, 1'b1, 1'b1, 32'h05FD_FE03, 32'h0701_0504},
    {2'b00, 1'b1, 1'b0, 1'b0, 32'hFF10_80C0, 32'h0AFF_7F40},
    {2'b01, 1'b0, 1'b0, 1'b1, 32'hFFFF_1234, 32'hFFFF_ABCD},
    {2'b01, 1'b0, 1'b1, 1'b0, 32'h8000_7FFF, 32'h8000_8001},
    {2'b01, 1'b1, 1'b1, 1'b1, 32'hFFF0_0100, 32'h0020_FF00},
    {2'b01, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'b10, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFD, 32'h0000_0007},
    {2'b10, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFD, 32'h0000_0007},
    {2'b10, 1'b1, 1'b1, 1'b1, 32'h8000_7FFF, 32'h7FFF_8000},
    {2'b11, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000}
  };

  function automatic logic signed [127:0] lane(input logic [31:0] x, input int k,
                                                input int lw, input logic s);
    logic signed [127:0] v;
    v = 128'(x >> (k*lw)) & ((128'(1) << lw) - 128'(1));
    if (s && v[lw-1]) v = v - (128'(1) << lw);
    return v;
  endfunction

  function automatic logic [95:0] model(input logic [95:0] acc, input logic [1:0] w,
      input logic c, input logic s, input logic clr, input logic [31:0] a, input logic [31:0] b);
    int lw, n, fw;
    logic [95:0] res, mask, old, nv;
    logic signed [127:0] term;
    lw = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : (c ? 16 : 32);
    n = 32 / lw;
    fw = 3 * lw;
    mask = (96'(1) << fw) - 96'(1);
    res = acc;
    for (int k = 0; k < n; k++) begin
      if (!c) term = lane(a,k,lw,s) * lane(b,k,lw,s);
      else if (k % 2 == 0) term = lane(a,k,lw,s) * lane(b,k,lw,s) - lane(a,k+1,lw,s) * lane(b,k+1,lw,s);
      else term = lane(a,k-1,lw,s) * lane(b,k,lw,s) + lane(a,k,lw,s) * lane(b,k-1,lw,s);
      old = clr ? '0 : ((acc >> (k*fw)) & mask);
      nv = (old + term[95:0]) & mask;
      res = (res & ~(mask << (k*fw))) | (nv << (k*fw));
    end
    return res;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] w, input logic c, input logic s, input logic clr,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_width = w; in_cplx = c; in_signed = s; in_clear = clr;
    in_a = a; in_b = b;
    #0.5;
    while (!in_ready) begin @(negedge clk); #0.5; end
    model_acc = model(model_acc, w, c, s, clr, a, b);
    qexp.push_back(model_acc);
    qcyc.push_back(cyc + 3);
    qtag.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (qexp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [95:0] e;
    int c;
    string t;
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (qexp.size() == 0) chk(1'b0, "R11 unexpected output beat", out_acc, '0);
      else begin
        e = qexp.pop_front(); c = qcyc.pop_front(); t = qtag.pop_front();
        chk(out_acc == e, t, out_acc, e);
        if (lat_on) chk(cyc == c, "R7 latency", 96'(cyc), 96'(c));
      end
    end
  end

  initial begin
    logic [95:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 96'(out_valid), 96'd0);
    chk(out_acc == '0, "R1 accumulators after reset", out_acc, '0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 96'(in_ready), 96'd1);

    // table burst, back to back, mode changes on every beat
    foreach (VEC[i]) begin
      send(VEC[i][68:67], VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0],
           VEC[i][66] ? "R4 R5 R8 burst" : "R2 R8 burst");
    end
    drain();

    // R4: 8-bit complex, (3 - 2j) * (4 + 5j) = 22 + 7j
    send(2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_FE03, 32'h0000_0504, "R4 8-bit complex");
    drain();
    chk(out_acc == {48'd0, 24'd7, 24'd22}, "R4 hand value", out_acc, {48'd0, 24'd7, 24'd22});

    // R5: 32-bit code complex on halves, (-1 + 2j) * (4 + 3j) = -10 + 5j
    send(2'b10, 1'b1, 1'b1, 1'b1, 32'h0002_FFFF, 32'h0003_0004, "R5 32-bit complex");
    drain();
    chk(out_acc == {48'd5, 48'hFFFF_FFFF_FFF6}, "R5 hand value", out_acc, {48'd5, 48'hFFFF_FFFF_FFF6});

    // R3: same bits read unsigned then signed
    send(2'b01, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, "R2 R3 unsigned");
    drain();
    chk(out_acc == 96'h0000_FFFE_0001, "R3 unsigned value", out_acc, 96'h0000_FFFE_0001);
    send(2'b01, 1'b0, 1'b1, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, "R2 R3 signed");
    drain();
    chk(out_acc == 96'd1, "R3 signed value", out_acc, 96'd1);

    // R9: field wraps and no carry leaks to neighbours
    for (int n = 0; n < 300; n++)
      send(2'b00, 1'b0, 1'b0, (n == 0), 32'h0000_00FF, 32'h0000_00FF, "R9 wrap run");
    drain();
    chk(out_acc == {72'd0, 24'd2730284}, "R9 wrapped field", out_acc, {72'd0, 24'd2730284});

    // R6: clear loads the new product only
    send(2'b00, 1'b0, 1'b0, 1'b1, 32'h0000_0002, 32'h0000_0003, "R6 clear");
    drain();
    chk(out_acc == 96'd6, "R6 clear value", out_acc, 96'd6);

    // R11: idle cycles with busy inputs change nothing
    hold = out_acc;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      in_valid = 1'b0; in_clear = 1'b1; in_a = 32'hDEAD_0000 + n; in_b = 32'hBEEF_1234;
    end
    @(negedge clk); #1;
    chk(out_acc == hold, "R11 idle hold", out_acc, hold);

    // R10: back-pressure
    lat_on = 1'b0;
    @(negedge clk); out_ready = 1'b0;
    send(2'b00, 1'b0, 1'b0, 1'b1, 32'h0403_0201, 32'h0101_0101, "R10 stalled beat 1");
    send(2'b00, 1'b0, 1'b0, 1'b0, 32'h0101_0101, 32'h0202_0202, "R10 stalled beat 2");
    send(2'b01, 1'b0, 1'b1, 1'b0, 32'h0010_0010, 32'h0003_0003, "R10 stalled beat 3");
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'hFFFF_FFFF; in_b = 32'hFFFF_FFFF; in_clear = 1'b1;
    #1; hold = out_acc;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); #1;
      chk(in_ready == 1'b0, "R10 in_ready low", 96'(in_ready), 96'd0);
      chk(out_valid == 1'b1, "R10 out_valid held", 96'(out_valid), 96'd1);
      chk(out_acc == hold, "R10 out_acc held", out_acc, hold);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    drain();
    lat_on = 1'b1;
    chk(qexp.size() == 0, "R10 all beats delivered", 96'(qexp.size()), 96'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule